// File: doc/BRIEF.md
# Dual-Port RAM with Selectable Latency

A true dual-port synchronous memory of 36-bit words. Each of the two ports, left and right, has its own clock and registers its control, address and write data on the rising edge. Either port can read or write any word in the same cycle as the other port, including the same word. Each port has a strap input that selects its read timing. Flow-through mode shows the read word in the cycle after the address edge. Pipelined mode adds one output register and so one more cycle.

The word is split into four 9-bit lanes. The left port has a lane-enable input per lane, which gates both what it writes and what it reads. The right port always moves whole words. Each port has an active-low chip enable that deselects it, and an asynchronous active-low output enable. Because the block has no tri-state pins, every port has a data output and a drive flag: the output is zero whenever the flag is low.

When both ports write the same word in the same cycle, the left port's lanes win. A clash flag marks that cycle. The clash rule assumes that both ports run from a common clock. The depth is set by an address-width parameter.

Top module: `dpr_sel_ram`

## Requirements
- R1: In flow-through mode (pipe input low), a read whose address is captured at rising edge k shows the stored word on the data output after edge k, with the drive flag high.
- R2: In pipelined mode (pipe input high), a read captured at edge k leaves the drive flag low after edge k when the previous cycle did not read, and shows the word after edge k+1.
- R3: The drive flag is high only while output enable is low and a read is being presented. Output enable acts without waiting for a clock. While the drive flag is low, the data output is all zeros.
- R4: A cycle with chip enable low and the read/write input low (0 = write, 1 = read) stores the write data at the captured address, and the port does not drive its output for that cycle.
- R5: A word written on one port is returned by a read on the other port whose address is captured at or after the edge that follows the write's capture edge. A read captured at the same edge as the write returns the old word.
- R6: Left lane enable bit n covers word bits 9n+8 down to 9n. A left write changes only the enabled lanes. A left read returns zero in lanes whose enable is low.
- R7: When both ports write the same address in the same cycle, the lanes written by the left port take the left data. Lanes the left port does not write take the right data. The clash flag is high for that cycle.
- R8: Chip enable high deselects a port and blocks writes. In flow-through mode the output stops being driven after the edge that captures the deselect. In pipelined mode it stops one edge later. Reactivation follows the same timing.
- R9: While reset is active and after its release, both drive flags are low, both data outputs are zero, and the clash flag is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_l | input | 1 | Left port clock |
| rst_n | input | 1 | Asynchronous active-low reset for both ports |
| l_pipe | input | 1 | Left strap: 0 flow-through, 1 pipelined |
| l_ce_n | input | 1 | Left chip enable, active low |
| l_rw | input | 1 | Left read (1) or write (0) |
| l_oe_n | input | 1 | Left output enable, active low, asynchronous |
| l_lane_en | input | 4 | Left lane enables, bit n covers bits 9n+8:9n |
| l_addr | input | ADDR_W | Left word address |
| l_din | input | 36 | Left write data |
| l_dout | output | 36 | Left read data, zero when not driven |
| l_drive | output | 1 | Left output drive flag |
| clk_r | input | 1 | Right port clock |
| r_pipe | input | 1 | Right strap: 0 flow-through, 1 pipelined |
| r_ce_n | input | 1 | Right chip enable, active low |
| r_rw | input | 1 | Right read (1) or write (0) |
| r_oe_n | input | 1 | Right output enable, active low, asynchronous |
| r_addr | input | ADDR_W | Right word address |
| r_din | input | 36 | Right write data |
| r_dout | output | 36 | Right read data, zero when not driven |
| r_drive | output | 1 | Right output drive flag |
| wr_clash | output | 1 | Both ports write the same address this cycle |

## Verification
A wrong owner bit in a lane's value table shows up on the next read of that word: the read returns the other bank's stale lane, one cycle later in flow-through mode or two cycles later in pipelined mode. A mis-timed output stage shows up as the drive flag rising or falling one edge early or late around a read or a chip-enable change. A lane-mask fault corrupts only the 9-bit field it covers, and only on the left port. A collision fault shows up as right-port data appearing in a lane the left port wrote in the same cycle.

// File: rtl/dpr_pkg.sv
package dpr_pkg;
   localparam int unsigned LANES  = 4;
   localparam int unsigned LANE_W = 9;
   localparam int unsigned WORD_W = LANES * LANE_W;
endpackage

// File: rtl/dpr_lane_store.sv
// One 9-bit lane: a bank per writer plus a live-value table of owner bits.
module dpr_lane_store #(
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned LANE_W = 9
) (
   input  logic              clk_l,
   input  logic              clk_r,
   input  logic              rst_n,
   input  logic              l_we,
   input  logic [ADDR_W-1:0] l_addr,
   input  logic [LANE_W-1:0] l_din,
   input  logic              r_we,
   input  logic [ADDR_W-1:0] r_addr,
   input  logic [LANE_W-1:0] r_din,
   output logic [LANE_W-1:0] l_rdata,
   output logic [LANE_W-1:0] r_rdata
);
   localparam int unsigned DEPTH = 1 << ADDR_W;

   logic [LANE_W-1:0] bank_l [DEPTH];
   logic [LANE_W-1:0] bank_r [DEPTH];
   logic [DEPTH-1:0]  own_l;
   logic [DEPTH-1:0]  own_r;

   // owner bits: equal -> left bank is live, different -> right bank is live
   always_ff @(posedge clk_l or negedge rst_n) begin
      if (!rst_n)    own_l <= '0;
      else if (l_we) own_l[l_addr] <= own_r[l_addr];
   end

   always_ff @(posedge clk_r or negedge rst_n) begin
      if (!rst_n)    own_r <= '0;
      else if (r_we) own_r[r_addr] <= ~own_l[r_addr];
   end

   always_ff @(posedge clk_l) begin
      if (l_we) bank_l[l_addr] <= l_din;
   end

   always_ff @(posedge clk_r) begin
      if (r_we) bank_r[r_addr] <= r_din;
   end

   function automatic logic [LANE_W-1:0] peek(input logic [ADDR_W-1:0] a);
      return (own_l[a] ^ own_r[a]) ? bank_r[a] : bank_l[a];
   endfunction

   assign l_rdata = peek(l_addr);
   assign r_rdata = peek(r_addr);

   // R7: the top must have removed the right write before two writers meet here
   assert_single_writer_R7: assert property (@(posedge clk_l) disable iff (!rst_n)
      (l_we && r_we) |-> (l_addr != r_addr));

   // R5: a left write is visible in the array at the following edge
   assert_write_lands_R5: assert property (@(posedge clk_l) disable iff (!rst_n)
      l_we |=> (peek($past(l_addr)) == $past(l_din)));
endmodule

// File: rtl/dpr_port_side.sv
// Input register stage plus flow-through / pipelined output stage of one port.
module dpr_port_side #(
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned LANES  = 4,
   parameter int unsigned LANE_W = 9,
   localparam int unsigned DATA_W = LANES * LANE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pipe_mode,
   input  logic              ce_n,
   input  logic              rw,
   input  logic              oe_n,
   input  logic [LANES-1:0]  lane_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] din,
   input  logic [DATA_W-1:0] rdata,
   output logic [LANES-1:0]  wr_lanes,
   output logic [ADDR_W-1:0] q_addr,
   output logic [DATA_W-1:0] q_din,
   output logic [DATA_W-1:0] dout,
   output logic              drive
);
   logic             q_sel;
   logic             q_rw;
   logic [LANES-1:0] q_lane;
   logic             q_rd;
   logic [DATA_W-1:0] masked;
   logic [DATA_W-1:0] p_data;
   logic             p_act;
   logic [DATA_W-1:0] out_data;
   logic             out_act;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_sel  <= 1'b0;
         q_rw   <= 1'b1;
         q_lane <= '0;
         q_addr <= '0;
         q_din  <= '0;
      end else begin
         q_sel  <= ~ce_n;
         q_rw   <= rw;
         q_lane <= lane_en;
         q_addr <= addr;
         q_din  <= din;
      end
   end

   assign q_rd     = q_sel & q_rw;
   assign wr_lanes = {LANES{q_sel & ~q_rw}} & q_lane;

   for (genvar n = 0; n < LANES; n++) begin : g_mask
      assign masked[n*LANE_W +: LANE_W] = q_lane[n] ? rdata[n*LANE_W +: LANE_W] : '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         p_data <= '0;
         p_act  <= 1'b0;
      end else begin
         p_data <= masked;
         p_act  <= q_rd;
      end
   end

   assign out_data = pipe_mode ? p_data : masked;
   assign out_act  = pipe_mode ? p_act  : q_rd;
   assign drive    = ~oe_n & out_act;
   assign dout     = drive ? out_data : '0;

   assert_flow_read_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (!pipe_mode && $past(!ce_n && rw) && !oe_n) |-> drive);

   assert_pipe_lag_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (pipe_mode && $past(pipe_mode) && $past(!ce_n && rw, 2) && !oe_n) |-> drive);

   assert_write_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!pipe_mode && $past(!ce_n && !rw)) |-> !drive);

   assert_flow_deselect_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!pipe_mode && $past(ce_n)) |-> !drive);

   assert_pipe_deselect_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (pipe_mode && $past(pipe_mode) && $past(ce_n, 2)) |-> !drive);
endmodule

// File: rtl/dpr_sel_ram.sv
module dpr_sel_ram
   import dpr_pkg::*;
#(
   parameter int unsigned ADDR_W = 8
) (
   input  logic              clk_l,
   input  logic              rst_n,
   input  logic              l_pipe,
   input  logic              l_ce_n,
   input  logic              l_rw,
   input  logic              l_oe_n,
   input  logic [LANES-1:0]  l_lane_en,
   input  logic [ADDR_W-1:0] l_addr,
   input  logic [WORD_W-1:0] l_din,
   output logic [WORD_W-1:0] l_dout,
   output logic              l_drive,
   input  logic              clk_r,
   input  logic              r_pipe,
   input  logic              r_ce_n,
   input  logic              r_rw,
   input  logic              r_oe_n,
   input  logic [ADDR_W-1:0] r_addr,
   input  logic [WORD_W-1:0] r_din,
   output logic [WORD_W-1:0] r_dout,
   output logic              r_drive,
   output logic              wr_clash
);
   if (ADDR_W < 1 || ADDR_W > 12) begin : g_bad_addr_w
      $error("dpr_sel_ram: ADDR_W must lie in 1..12");
   end
   if (LANE_W * LANES != WORD_W) begin : g_bad_lanes
      $error("dpr_sel_ram: lane split does not cover the word");
   end

   logic [LANES-1:0]  l_wr, r_wr, r_wr_eff;
   logic [ADDR_W-1:0] l_qa, r_qa;
   logic [WORD_W-1:0] l_qd, r_qd, l_rdata, r_rdata;

   dpr_port_side #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_left (
      .clk(clk_l), .rst_n(rst_n), .pipe_mode(l_pipe), .ce_n(l_ce_n), .rw(l_rw),
      .oe_n(l_oe_n), .lane_en(l_lane_en), .addr(l_addr), .din(l_din),
      .rdata(l_rdata), .wr_lanes(l_wr), .q_addr(l_qa), .q_din(l_qd),
      .dout(l_dout), .drive(l_drive));

   dpr_port_side #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_right (
      .clk(clk_r), .rst_n(rst_n), .pipe_mode(r_pipe), .ce_n(r_ce_n), .rw(r_rw),
      .oe_n(r_oe_n), .lane_en({LANES{1'b1}}), .addr(r_addr), .din(r_din),
      .rdata(r_rdata), .wr_lanes(r_wr), .q_addr(r_qa), .q_din(r_qd),
      .dout(r_dout), .drive(r_drive));

   // left wins: right write dropped in every lane the left port writes
   assign wr_clash = (|l_wr) && (|r_wr) && (l_qa == r_qa);
   assign r_wr_eff = r_wr & ~({LANES{wr_clash}} & l_wr);

   for (genvar n = 0; n < LANES; n++) begin : g_lane
      dpr_lane_store #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_store (
         .clk_l(clk_l), .clk_r(clk_r), .rst_n(rst_n),
         .l_we(l_wr[n]), .l_addr(l_qa), .l_din(l_qd[n*LANE_W +: LANE_W]),
         .r_we(r_wr_eff[n]), .r_addr(r_qa), .r_din(r_qd[n*LANE_W +: LANE_W]),
         .l_rdata(l_rdata[n*LANE_W +: LANE_W]),
         .r_rdata(r_rdata[n*LANE_W +: LANE_W]));
   end

   assert_clash_needs_writes_R7: assert property (@(posedge clk_l) disable iff (!rst_n)
      wr_clash |-> ($past(!l_ce_n && !l_rw) && $past(!r_ce_n && !r_rw)));
endmodule

// File: tb/tb_dpr_sel_ram.sv
module tb_dpr_sel_ram;
   localparam int AW = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic l_pipe = 1'b0, l_ce_n = 1'b1, l_rw = 1'b1, l_oe_n = 1'b0;
   logic [3:0] l_lane_en = 4'hF;
   logic [AW-1:0] l_addr = '0;
   logic [35:0] l_din = '0;
   logic [35:0] l_dout;
   logic l_drive;
   logic r_pipe = 1'b1, r_ce_n = 1'b1, r_rw = 1'b1, r_oe_n = 1'b0;
   logic [AW-1:0] r_addr = '0;
   logic [35:0] r_din = '0;
   logic [35:0] r_dout;
   logic r_drive;
   logic wr_clash;

   int checks = 0;
   int fails = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   dpr_sel_ram #(.ADDR_W(AW)) dut (
      .clk_l(clk), .rst_n(rst_n), .l_pipe(l_pipe), .l_ce_n(l_ce_n), .l_rw(l_rw),
      .l_oe_n(l_oe_n), .l_lane_en(l_lane_en), .l_addr(l_addr), .l_din(l_din),
      .l_dout(l_dout), .l_drive(l_drive), .clk_r(clk), .r_pipe(r_pipe),
      .r_ce_n(r_ce_n), .r_rw(r_rw), .r_oe_n(r_oe_n), .r_addr(r_addr),
      .r_din(r_din), .r_dout(r_dout), .r_drive(r_drive), .wr_clash(wr_clash));

   localparam logic [35:0] D0 = 36'h0_1111_2222;
   localparam logic [35:0] D1 = 36'h9_1234_5678;
   localparam logic [35:0] D2 = 36'hA_BCDE_F012;
   localparam logic [35:0] VA = 36'h5_5555_5555;
   localparam logic [35:0] VB = 36'hC_3C3C_3C3C;
   localparam logic [35:0] VE = 36'h7_0F0F_0F0F;
   localparam logic [35:0] VF = 36'h8_F0F0_F0F0;

   function automatic logic [35:0] lane_mix(input logic [35:0] base, input logic [35:0] over,
                                            input logic [3:0] sel);
      logic [35:0] r = base;
      for (int n = 0; n < 4; n++)
         if (sel[n]) r[n*9 +: 9] = over[n*9 +: 9];
      return r;
   endfunction

   task automatic chk(input string tag, input logic [35:0] got, input logic [35:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic l_idle(); l_ce_n = 1'b1; l_rw = 1'b1; l_lane_en = 4'hF; endtask
   task automatic r_idle(); r_ce_n = 1'b1; r_rw = 1'b1; endtask

   task automatic l_set(input logic wr, input logic [AW-1:0] a, input logic [35:0] d,
                        input logic [3:0] lanes);
      l_ce_n = 1'b0; l_rw = ~wr; l_addr = a; l_din = d; l_lane_en = lanes;
   endtask

   task automatic r_set(input logic wr, input logic [AW-1:0] a, input logic [35:0] d);
      r_ce_n = 1'b0; r_rw = ~wr; r_addr = a; r_din = d;
   endtask

   task automatic t_reset();
      chk("R9 left drive in reset", {35'd0, l_drive}, 36'd0);
      chk("R9 left data in reset", l_dout, 36'd0);
      chk("R9 right drive in reset", {35'd0, r_drive}, 36'd0);
      chk("R9 clash in reset", {35'd0, wr_clash}, 36'd0);
      rst_n = 1'b1;
      step();
      chk("R9 left drive after reset", {35'd0, l_drive}, 36'd0);
      chk("R9 right data after reset", r_dout, 36'd0);
   endtask

   task automatic t_flow_rw();
      l_set(1'b1, 8'd5, D1, 4'hF);
      step();
      chk("R4 no drive in write cycle", {35'd0, l_drive}, 36'd0);
      l_set(1'b0, 8'd5, '0, 4'hF);
      step();
      chk("R1 flow-through drive", {35'd0, l_drive}, 36'd1);
      chk("R1 flow-through data", l_dout, D1);
      l_idle();
      step();
   endtask

   task automatic t_pipe_read();
      r_set(1'b0, 8'd5, '0);
      step();
      chk("R2 pipelined not yet driven", {35'd0, r_drive}, 36'd0);
      step();
      chk("R2 pipelined data one edge later", r_dout, D1);
      r_idle();
      step();
      step();
   endtask

   task automatic t_cross_port();
      r_set(1'b1, 8'd9, D0);
      step();
      r_idle();
      step();
      l_set(1'b1, 8'd9, D2, 4'hF);
      r_set(1'b0, 8'd9, '0);
      step();
      l_idle();
      step();
      chk("R5 same-edge read returns old word", r_dout, D0);
      step();
      chk("R5 later read returns new word", r_dout, D2);
      // R3: output enable acts without a clock
      r_oe_n = 1'b1;
      #1;
      chk("R3 oe high drops drive", {35'd0, r_drive}, 36'd0);
      chk("R3 oe high zeroes data", r_dout, 36'd0);
      r_oe_n = 1'b0;
      #1;
      chk("R3 oe low restores data", r_dout, D2);
      r_idle();
      step();
      step();
   endtask

   task automatic t_lanes();
      r_set(1'b1, 8'd12, VA);
      step();
      r_idle();
      l_set(1'b1, 8'd12, VB, 4'b0101);
      step();
      l_set(1'b0, 8'd12, '0, 4'hF);
      step();
      chk("R6 partial write keeps other lanes", l_dout, lane_mix(VA, VB, 4'b0101));
      l_set(1'b0, 8'd12, '0, 4'b0011);
      step();
      chk("R6 disabled lanes read zero", l_dout,
          lane_mix(36'd0, lane_mix(VA, VB, 4'b0101), 4'b0011));
      l_idle();
      step();
   endtask

   task automatic t_clash();
      r_set(1'b1, 8'd20, D0);
      step();
      l_set(1'b1, 8'd20, VE, 4'b0011);
      r_set(1'b1, 8'd20, VF);
      step();
      chk("R7 clash flag high", {35'd0, wr_clash}, 36'd1);
      l_idle();
      r_idle();
      step();
      chk("R7 clash flag clears", {35'd0, wr_clash}, 36'd0);
      l_set(1'b0, 8'd20, '0, 4'hF);
      step();
      chk("R7 left lanes win", l_dout, lane_mix(VF, VE, 4'b0011));
      l_idle();
      step();
   endtask

   task automatic t_deselect();
      l_set(1'b0, 8'd5, '0, 4'hF);
      step();
      chk("R8 flow active before deselect", l_dout, D1);
      l_ce_n = 1'b1;
      step();
      chk("R8 flow deselect immediate", {35'd0, l_drive}, 36'd0);
      l_set(1'b0, 8'd5, '0, 4'hF);
      step();
      chk("R8 flow reactivation immediate", l_dout, D1);
      l_idle();
      r_set(1'b0, 8'd5, '0);
      step();
      step();
      chk("R8 pipelined active", r_dout, D1);
      r_ce_n = 1'b1;
      step();
      chk("R8 pipelined still driven one edge", {35'd0, r_drive}, 36'd1);
      step();
      chk("R8 pipelined deselected", {35'd0, r_drive}, 36'd0);
      r_set(1'b0, 8'd5, '0);
      step();
      chk("R8 pipelined reactivation delayed", {35'd0, r_drive}, 36'd0);
      step();
      chk("R8 pipelined reactivated", r_dout, D1);
      r_idle();
      // blocked write while deselected
      l_ce_n = 1'b1; l_rw = 1'b0; l_addr = 8'd5; l_din = VB;
      step();
      step();
      l_set(1'b0, 8'd5, '0, 4'hF);
      step();
      chk("R8 deselected write blocked", l_dout, D1);
      l_idle();
      step();
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1;
      t_reset();
      t_flow_rw();
      t_pipe_read();
      t_cross_port();
      t_lanes();
      t_clash();
      t_deselect();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule